// File: doc/BRIEF.md
# Power-of-Two Clock Post-Divider with Gated Output

This block sits between a buffered reference clock and an output pad driver. It divides the reference by 1, 2, 4, 8 or 16, and it gates the result with one control pin. The pin has two possible roles. In the power-down role the output stays driven and rests low while stopped. In the output-enable role the output driver is released to high impedance.

A configuration bit picks the role of the control pin. A second bit picks how the stop and start happen. In synchronous mode the pin is brought into the reference domain first. Any high phase already in progress is finished, and restarts happen only on a cycle boundary, so the output never carries a runt pulse. In asynchronous mode a low level on the pin cuts the output at once, without waiting for any clock edge.

After a power-down is released, a startup counter holds the output off for a fixed number of reference cycles. This counter models the settle time of the oscillator. A change of divide ratio waits until the current low phase ends.

Top module: `clk_postdiv`

## Requirements
- R1: For cfg_div_sel values 0 to 4 the output period is 2^cfg_div_sel reference cycles. For values 1 to 4, the high phase and the low phase each last 2^(cfg_div_sel-1) reference cycles. For value 0 the output is high during the high half of each reference cycle.
- R2: cfg_div_sel values 5, 6 and 7 all divide by 16.
- R3: A new cfg_div_sel value is applied only when a low phase of the output ends. Every high pulse therefore has the full width of either the old ratio or the new ratio.
- R4: cfg_oe_mode selects the role of ctl_in. With cfg_oe_mode = 0, ctl_in is an active-low power-down. With cfg_oe_mode = 1, ctl_in is an output enable, and a low level disables the output.
- R5: In the power-down role, clk_out_en is 1 from the second reference edge after reset release onward, and clk_out rests low while stopped.
- R6: In the output-enable role, a disabled output has clk_out_en = 0 and clk_out low. clk_out is never high while clk_out_en is 0.
- R7: With cfg_async = 0, ctl_in passes through a two-flop synchronizer. clk_out shows no new rising edge later than the third reference edge after ctl_in falls. A high phase already in progress completes, and no high pulse is shorter than the selected ratio's high phase.
- R8: With cfg_async = 0, a re-enabled output restarts at a cycle boundary with a full high phase. In the output-enable role it restarts within 3 + 2^cfg_div_sel reference cycles after ctl_in rises.
- R9: With cfg_async = 1, ctl_in low forces clk_out low immediately, with no clock edge needed. In the output-enable role it also forces clk_out_en low.
- R10: In the power-down role, clk_out has no rising edge for STARTUP_CYCLES reference cycles after ctl_in rises, or after reset is released with ctl_in high. After that interval the output resumes.
- R11: Reset is synchronous and active low. While it is held, clk_out is low and clk_out_en is low, and the divider counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Buffered reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div_sel | input | 3 | Divide select, ratio 2^value (5 to 7 act as 16) |
| cfg_oe_mode | input | 1 | Control pin role: 0 power-down, 1 output enable |
| cfg_async | input | 1 | 0 synchronous gating, 1 immediate gating |
| ctl_in | input | 1 | Control pin, active-high run |
| clk_out | output | 1 | Divided, gated clock |
| clk_out_en | output | 1 | Drive enable for the tri-state output buffer |

## Verification
Some properties are checked on every cycle. In the output-enable role, clk_out is never high while the driver is released. In synchronous mode, the gate opens only where a high phase starts and closes only where the output is low. In asynchronous mode, a low control pin forces the output off. A ratio change lands only at the end of a low phase, and the power-down role keeps the driver on. Other behaviours span many cycles and are shown only by the bench's directed scenarios: the measured period and duty cycle for each select value, the stop latency after the pin falls, the full width of the first pulse after restart, the length of the startup hold-off, and the output state during a reset applied mid-run.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the clock post-divider.
// Assumes: nothing beyond IEEE 1800-2017.
package pdiv_pkg;

    // Role of the single control pin.
    typedef enum logic {
        CTL_POWER_DOWN = 1'b0,
        CTL_OUT_ENABLE = 1'b1
    } ctl_role_e;

    // Timing of the gate action.
    typedef enum logic {
        GATE_SYNC  = 1'b0,
        GATE_ASYNC = 1'b1
    } gate_timing_e;

endpackage

// File: rtl/pdiv_divider.sv
`timescale 1ns/1ps
// Module: pdiv_divider
// Divides the reference clock by 2^k, with k taken from the select input.
// Select values above LOG2_MAX are clamped. A new ratio is loaded only
// when the counter wraps, which is where a low phase ends. The module
// reports two gate windows: where a high phase starts, and where the
// next state of the output is low.
// Assumes: rst_n is synchronous to clk, and sel is quasi-static.
module pdiv_divider #(
    parameter int LOG2_MAX = 4,
    parameter int KW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] sel,
    output logic          div_q,
    output logic [KW-1:0] k_act,
    output logic          is_div1,
    output logic          wrap,
    output logic          start_ok,
    output logic          stop_ok
);
    localparam int CNT_W = LOG2_MAX + 1;

    logic [KW-1:0]    k_req;
    logic [KW-1:0]    k_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] last_v;
    logic [CNT_W-1:0] half_nx;
    logic             div_nx;

    // Clamp the requested exponent to the largest supported ratio.
    always_comb begin
        if (sel > KW'(LOG2_MAX)) begin
            k_req = KW'(LOG2_MAX);
        end else begin
            k_req = sel;
        end
    end

    // Next-state of the counter, the ratio and the divided level.
    always_comb begin
        last_v  = (CNT_W'(1) << k_act) - CNT_W'(1);
        wrap    = (cnt_q == last_v);
        k_nx    = wrap ? k_req : k_act;
        cnt_nx  = wrap ? '0 : cnt_q + 1'b1;
        half_nx = (k_nx == '0) ? '0 : (CNT_W'(1) << (k_nx - 1'b1));
        div_nx  = (k_nx == '0) ? 1'b1 : (cnt_nx < half_nx);
    end

    // Gate windows, expressed in terms of the next output state.
    always_comb begin
        is_div1  = (k_act == '0);
        start_ok = is_div1 | wrap;
        stop_ok  = is_div1 | ~div_nx;
    end

    // Counter, active ratio and divided-clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            k_act <= k_req;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            k_act <= k_nx;
            div_q <= div_nx;
        end
    end

endmodule

// File: rtl/pdiv_gate_ctrl.sv
`timescale 1ns/1ps
// Module: pdiv_gate_ctrl
// Brings the control pin into the reference domain and runs the startup
// hold-off for the power-down role. It then decides when the output gate
// opens or closes. In synchronous timing the gate moves only inside the
// windows supplied by the divider. In asynchronous timing it follows the
// request at the next edge.
// Assumes: SYNC_STAGES >= 2 and STARTUP_CYCLES >= 1.
module pdiv_gate_ctrl #(
    parameter int STARTUP_CYCLES = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_in,
    input  logic oe_mode,
    input  logic async_mode,
    input  logic start_ok,
    input  logic stop_ok,
    output logic run_q,
    output logic pd_en_q
);
    import pdiv_pkg::*;

    localparam int SW = $clog2(STARTUP_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ctl_s;
    logic [SW-1:0]          settle_q;
    logic                   settled_q;
    logic                   want;
    logic                   run_nx;

    // Synchronizer chain for the control pin.
    generate
        if (SYNC_STAGES == 2) begin : g_sync2
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[0], ctl_in};
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ctl_in};
            end
        end
    endgenerate

    assign ctl_s = sync_q[SYNC_STAGES-1];

    // Startup hold-off counter: restarts whenever the pin is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_s) begin
            settle_q  <= '0;
            settled_q <= 1'b0;
        end else if (!settled_q) begin
            if (settle_q == SW'(STARTUP_CYCLES - 1)) settled_q <= 1'b1;
            else                                     settle_q  <= settle_q + 1'b1;
        end
    end

    // Run request: the enable role needs no hold-off.
    assign want = ctl_s & ((ctl_role_e'(oe_mode) == CTL_OUT_ENABLE) | settled_q);

    // Next gate state: windowed in synchronous timing, direct otherwise.
    always_comb begin
        if (gate_timing_e'(async_mode) == GATE_ASYNC) begin
            run_nx = want;
        end else if (want && !run_q) begin
            run_nx = start_ok;
        end else if (!want && run_q) begin
            run_nx = !stop_ok;
        end else begin
            run_nx = run_q;
        end
    end

    // Gate register, and the driver enable used by the power-down role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pd_en_q <= 1'b0;
        end else begin
            run_q   <= run_nx;
            pd_en_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pdiv_out_stage.sv
`timescale 1ns/1ps
// Module: pdiv_out_stage
// Builds the pad-side clock and the driver enable. For divide-by-1, the
// reference clock passes through a latch-based gate that is transparent
// while the clock is low. For other ratios, the registered divided clock
// is ANDed with the registered gate. An immediate kill overrides both.
// Assumes: run_q and div_q are registered on the rising edge of ref_clk.
module pdiv_out_stage (
    input  logic ref_clk,
    input  logic run_q,
    input  logic div_q,
    input  logic is_div1,
    input  logic kill,
    input  logic oe_mode,
    input  logic pd_en_q,
    output logic clk_out,
    output logic clk_out_en
);
    logic gate_l;
    logic clk_raw;

    // Clock-gate latch: captures the gate only while ref_clk is low.
    always_latch begin
        if (!ref_clk) gate_l <= run_q;
    end

    // Select the divide-by-1 path or the registered path, then apply the kill.
    always_comb begin
        clk_raw = is_div1 ? (ref_clk & gate_l) : (div_q & run_q);
        clk_out = clk_raw & ~kill;
    end

    // Driver enable: it follows the gate in the enable role, else stays on.
    always_comb begin
        if (oe_mode) clk_out_en = (run_q | gate_l) & ~kill;
        else         clk_out_en = pd_en_q;
    end

endmodule

// File: rtl/clk_postdiv.sv
`timescale 1ns/1ps
// Module: clk_postdiv (top)
// Power-of-two clock post-divider with a control pin that gates it. The
// pin acts either as a power-down or as an output enable, and it acts
// either synchronously or immediately.
// Assumes: a single reference clock domain, and configuration inputs that
// are held static while the output is stopped or running.
module clk_postdiv #(
    parameter int LOG2_MAX       = 4,
    parameter int STARTUP_CYCLES = 64,
    parameter int SYNC_STAGES    = 2,
    parameter int KW             = $clog2(LOG2_MAX + 1)
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [KW-1:0] cfg_div_sel,
    input  logic          cfg_oe_mode,
    input  logic          cfg_async,
    input  logic          ctl_in,
    output logic          clk_out,
    output logic          clk_out_en
);
    logic          div_q;
    logic [KW-1:0] k_act;
    logic          is_div1;
    logic          wrap;
    logic          start_ok;
    logic          stop_ok;
    logic          run_q;
    logic          pd_en_q;
    logic          kill;

    // Immediate kill: raw pin level, used only in asynchronous timing.
    assign kill = cfg_async & ~ctl_in;

    pdiv_divider #(.LOG2_MAX(LOG2_MAX), .KW(KW)) u_div (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .sel      (cfg_div_sel),
        .div_q    (div_q),
        .k_act    (k_act),
        .is_div1  (is_div1),
        .wrap     (wrap),
        .start_ok (start_ok),
        .stop_ok  (stop_ok)
    );

    pdiv_gate_ctrl #(.STARTUP_CYCLES(STARTUP_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .ctl_in     (ctl_in),
        .oe_mode    (cfg_oe_mode),
        .async_mode (cfg_async),
        .start_ok   (start_ok),
        .stop_ok    (stop_ok),
        .run_q      (run_q),
        .pd_en_q    (pd_en_q)
    );

    pdiv_out_stage u_out (
        .ref_clk    (ref_clk),
        .run_q      (run_q),
        .div_q      (div_q),
        .is_div1    (is_div1),
        .kill       (kill),
        .oe_mode    (cfg_oe_mode),
        .pd_en_q    (pd_en_q),
        .clk_out    (clk_out),
        .clk_out_en (clk_out_en)
    );

endmodule

// File: rtl/clk_postdiv_sva.sv
`timescale 1ns/1ps
// Module: clk_postdiv_sva
// Checker bound into clk_postdiv. It watches the ports together with the
// gate, the divider and the ratio state.
// Assumes: ratio exponents fit in 8 bits.
module clk_postdiv_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_oe_mode,
    input logic       cfg_async,
    input logic       ctl_in,
    input logic       clk_out,
    input logic       clk_out_en,
    input logic       run_q,
    input logic       div_q,
    input logic       is_div1,
    input logic       wrap,
    input logic [7:0] k_act
);
    // R3: the active ratio changes only on a wrap edge.
    a_r3_ratio_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (k_act != $past(k_act))) |-> $past(wrap));

    // R5: the power-down role keeps the driver on.
    a_r5_pd_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_oe_mode |=> (cfg_oe_mode || clk_out_en));

    // R6: no high output while the driver is released.
    a_r6_hiz_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_mode && !clk_out_en) |-> !clk_out);

    // R7: a synchronous close lands only where the divided clock is low.
    a_r7_close_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cfg_async) && $past(!is_div1) && $fell(run_q)) |-> !div_q);

    // R8: a synchronous open lands only where a high phase starts.
    a_r8_open_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cfg_async) && $past(!is_div1) && $rose(run_q)) |-> div_q);

    // R9: a low pin in asynchronous timing forces the output off.
    a_r9_async_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_async && !ctl_in) |-> (!clk_out && (!cfg_oe_mode || !clk_out_en)));

endmodule

bind clk_postdiv clk_postdiv_sva u_sva (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .cfg_oe_mode (cfg_oe_mode),
    .cfg_async   (cfg_async),
    .ctl_in      (ctl_in),
    .clk_out     (clk_out),
    .clk_out_en  (clk_out_en),
    .run_q       (run_q),
    .div_q       (div_q),
    .is_div1     (is_div1),
    .wrap        (wrap),
    .k_act       (8'(k_act))
);

// File: tb/clk_postdiv_tb.sv
`timescale 1ns/1ps
// Directed bench for clk_postdiv: one task per scenario.
module clk_postdiv_tb;
    localparam int S = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd2;
    logic       oe = 1'b1;
    logic       asy = 1'b0;
    logic       ctl = 1'b1;
    logic       clk_out;
    logic       clk_out_en;

    int    nvec = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    int    n_rise = 0;
    bit    seen = 1'b0;
    longint t_rise = 0, last_per = 0, min_hi = 1000000, max_hi = 0;

    clk_postdiv #(.STARTUP_CYCLES(S)) u_dut (
        .ref_clk(clk), .rst_n(rst_n), .cfg_div_sel(sel), .cfg_oe_mode(oe),
        .cfg_async(asy), .ctl_in(ctl), .clk_out(clk_out), .clk_out_en(clk_out_en)
    );

    always #5 clk = ~clk;

    // Output pulse monitor: period, and high-phase width range.
    always @(posedge clk_out) begin
        if (seen) last_per = longint'($time) - t_rise;
        t_rise = longint'($time);
        seen   = 1'b1;
        n_rise++;
    end
    always @(negedge clk_out) begin
        if (seen) begin
            if (longint'($time) - t_rise < min_hi) min_hi = longint'($time) - t_rise;
            if (longint'($time) - t_rise > max_hi) max_hi = longint'($time) - t_rise;
        end
    end

    task automatic clr_stats();
        seen = 1'b0; n_rise = 0; last_per = 0; min_hi = 1000000; max_hi = 0;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // R11: output state while reset is held from time zero.
    task automatic t_reset_initial();
        cycles(4);
        chk("R11 reset clk_out", clk_out, 0);
        chk("R11 reset enable", clk_out_en, 0);
        @(negedge clk); rst_n = 1'b1;
        cycles(8);
    endtask

    // R1/R2: period and high width for one select value.
    task automatic t_ratio(input int s, input int n, input string req);
        sel = 3'(s);
        cycles(64);
        clr_stats();
        cycles(100);
        chk({req, " period"}, last_per, n * 10);
        chk({req, " min high"}, min_hi, n * 5);
        chk({req, " max high"}, max_hi, n * 5);
    endtask

    // R3: ratio change requested in mid-high phase of divide-by-4.
    task automatic t_sel_switch();
        sel = 3'd2; cycles(40);
        clr_stats();
        @(posedge clk_out); #3 sel = 3'd4;
        cycles(120);
        chk("R3 no short pulse", (min_hi >= 20) ? 1 : 0, 1);
        chk("R3 new period", last_per, 160);
        chk("R3 new high", max_hi, 80);
    endtask

    // R4-R8/R10: synchronous stop and restart in one role.
    task automatic t_sync(input bit role_oe, input int s, input int n);
        int snap;
        oe = role_oe; asy = 1'b0; sel = 3'(s); ctl = 1'b1;
        cycles(S + 40);
        clr_stats();
        @(posedge clk_out); @(negedge clk);
        ctl = 1'b0;
        if (n >= 2) begin
            #1 chk("R7 no immediate cut", clk_out, 1);
        end
        repeat (3) @(posedge clk);
        #1 snap = n_rise;
        cycles(4 * n + 4);
        chk("R7 no rise after stop", n_rise, snap);
        chk("R7 full pulses", min_hi, n * 5);
        chk("R5/R6 stopped low", clk_out, 0);
        chk(role_oe ? "R4/R6 enable off" : "R4/R5 enable on", clk_out_en, role_oe ? 0 : 1);
        @(negedge clk); ctl = 1'b1; snap = n_rise;
        if (!role_oe) begin
            cycles(S);
            chk("R10 startup hold", n_rise, snap);
        end
        cycles(n + 6);
        chk("R8 restart", (n_rise > snap) ? 1 : 0, 1);
        cycles(4 * n + 4);
        chk("R8 first pulse full", min_hi, n * 5);
        chk("R8 enable back", clk_out_en, 1);
    endtask

    // R9: immediate stop while the output is high.
    task automatic t_async(input bit role_oe, input int s, input int n);
        oe = role_oe; asy = 1'b1; sel = 3'(s); ctl = 1'b1;
        cycles(S + 40);
        @(posedge clk_out); #1 ctl = 1'b0;
        #1 chk("R9 output cut", clk_out, 0);
        chk("R9 enable", clk_out_en, role_oe ? 0 : 1);
        cycles(10);
        chk("R9 stays low", clk_out, 0);
        @(negedge clk); ctl = 1'b1;
        clr_stats();
        cycles(S + n + 10);
        chk("R9 resumes", (n_rise > 0) ? 1 : 0, 1);
        asy = 1'b0;
    endtask

    // R11: reset applied while the output runs.
    task automatic t_reset_mid();
        int snap;
        oe = 1'b1; asy = 1'b0; sel = 3'd2; ctl = 1'b1;
        cycles(40);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #2;
        chk("R11 mid reset clk_out", clk_out, 0);
        chk("R11 mid reset enable", clk_out_en, 0);
        snap = n_rise;
        cycles(6);
        chk("R11 no pulses in reset", n_rise, snap);
        @(negedge clk); rst_n = 1'b1;
        cycles(20);
        chk("R11 runs after reset", (n_rise > snap) ? 1 : 0, 1);
    endtask

    // R10/R5: reset released in the power-down role with the pin high.
    task automatic t_pd_powerup();
        int snap;
        @(negedge clk); rst_n = 1'b0; oe = 1'b0; sel = 3'd1; ctl = 1'b1;
        cycles(4);
        @(negedge clk); rst_n = 1'b1; snap = n_rise;
        cycles(S);
        chk("R10 power-up hold", n_rise, snap);
        chk("R5 driven after reset", clk_out_en, 1);
        cycles(12);
        chk("R10 power-up resume", (n_rise > snap) ? 1 : 0, 1);
    endtask

    initial begin
        t_reset_initial();
        t_ratio(0, 1, "R1 div1");
        t_ratio(1, 2, "R1 div2");
        t_ratio(2, 4, "R1 div4");
        t_ratio(3, 8, "R1 div8");
        t_ratio(4, 16, "R1 div16");
        t_ratio(5, 16, "R2 sel5");
        t_ratio(7, 16, "R2 sel7");
        t_sel_switch();
        t_sync(1'b1, 2, 4);
        t_sync(1'b0, 1, 2);
        t_sync(1'b1, 0, 1);
        t_sync(1'b0, 3, 8);
        t_async(1'b1, 0, 1);
        t_async(1'b0, 3, 8);
        t_reset_mid();
        t_pd_powerup();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule